// File: doc/BRIEF.md
# Strict-Priority Multi-Class Wavefront Arbiter

This block picks, for one cell transfer slot, a set of ingress-to-egress connections for a crossbar from a request matrix per traffic class. Each class has its own square array of processing elements. Inside an array, an ingress "hunting" token moves along its row and an egress "available" token moves down its column. A processing element that sees both tokens and a pending request for its pair claims the connection and absorbs both tokens.

The arrays are chained. The top class starts with every ingress hunting and every egress available. Each lower class is offered only the tokens that the class above did not absorb, so a higher class always wins over a lower one. The caller presents the request matrices and pulses `start`. One clock later, `done` is high and the registered results show, for each ingress, whether it was matched, to which egress, and in which class. The results then hold until the next `start`.

Top module: `prio_wavefront_arb`

## Requirements
- R1: While reset is asserted, `match_vld`, `match_egr`, `match_cls` and `done` are all zero.
- R2: `done` is high in the cycle after a clock edge at which `start` was high, and low in the cycle after an edge at which `start` was low.
- R3: At an edge where `start` is low, the results do not change, whatever `req` does.
- R4: Request bit `req[(c*N + i)*N + j]` means class c asks to connect ingress i to egress j. Class 0 is the highest class. Within class 0, ingresses are served in ascending index order, and each takes the lowest-numbered egress that is still free and that it requests.
- R5: Class 1 is offered only the ingresses left unmatched and the egresses left free by class 0, using the same ordering rule. After the last class, no unmatched ingress has a request in any class to a free egress.
- R6: The combined result is a partial permutation: no egress is reported for two matched ingresses, and each ingress has at most one grant across all classes.
- R7: For a matched ingress, `match_cls` holds the winning class index (0 or 1) and `match_egr` holds the egress index. For an unmatched ingress, both fields are zero.
- R8: When class 0 requests nothing, the class 1 matches are exactly those that a single-class arbiter produces for the class 1 matrix alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate `req` at this edge and load the results |
| req | input | C*N*N | Request matrices, class-major, then ingress, then egress |
| match_vld | output | N | Per-ingress match flag |
| match_egr | output | N*EW | Per-ingress egress index, EW bits each |
| match_cls | output | N*CW | Per-ingress winning class, CW bits each |
| done | output | 1 | Results valid, one cycle after `start` |

## Verification
The hardest situation to reach is one where class 0 takes an egress that a lower-numbered ingress wanted in class 1. That ingress must then fall through to a later egress, or stay unmatched, while a third ingress picks up what is left. Only particular combinations of the two matrices produce this chain of displacements. The stimulus runs every one of the 65,536 class 0 matrices with class 1 empty, then every class 1 matrix with class 0 empty. It then runs several thousand pseudo-random pairs of dense matrices, where cross-class conflicts are frequent. Each trial is compared against a greedy model that serves classes in order, ingresses in order and egresses lowest first.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

  // Index of the lowest set bit; zero when the vector is empty.
  function automatic int first_set_idx(input logic [31:0] v);
    int r;
    r = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

  // Width of an index field for a count of items (at least one bit).
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

  // Flat position of one request bit: class-major, then ingress, then egress.
  function automatic int req_pos(input int n, input int cls, input int ing, input int egr);
    return (cls * n + ing) * n + egr;
  endfunction

endpackage

// File: rtl/wfa_cell.sv
module wfa_cell (
  input  logic hunt_i,
  input  logic avail_i,
  input  logic want_i,
  output logic hunt_o,
  output logic avail_o,
  output logic win_o
);
  assign win_o   = hunt_i & avail_i & want_i;
  assign hunt_o  = hunt_i & ~win_o;
  assign avail_o = avail_i & ~win_o;
endmodule

// File: rtl/wfa_array.sv
module wfa_array #(
  parameter int N = 4
) (
  input  logic [N-1:0]   hunt_in,
  input  logic [N-1:0]   avail_in,
  input  logic [N*N-1:0] want,
  output logic [N*N-1:0] win,
  output logic [N-1:0]   hunt_out,
  output logic [N-1:0]   avail_out
);
  // hrow[i][j] : hunting token entering column j of row i
  // acol[j][i] : available token entering row i of column j
  logic [N:0] hrow [N];
  logic [N:0] acol [N];

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign hrow[i][0] = hunt_in[i];
    assign acol[i][0] = avail_in[i];
    assign hunt_out[i]  = hrow[i][N];
    assign avail_out[i] = acol[i][N];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      wfa_cell u_cell (
        .hunt_i  (hrow[i][j]),
        .avail_i (acol[j][i]),
        .want_i  (want[i*N + j]),
        .hunt_o  (hrow[i][j+1]),
        .avail_o (acol[j][i+1]),
        .win_o   (win[i*N + j])
      );
    end
  end
endmodule

// File: rtl/wfa_encode.sv
module wfa_encode
  import wfa_pkg::*;
#(
  parameter int N  = 4,
  parameter int C  = 2,
  parameter int EW = 2,
  parameter int CW = 1
) (
  input  logic [C*N*N-1:0] grant_all,
  output logic [N-1:0]     vld,
  output logic [N*EW-1:0]  egr,
  output logic [N*CW-1:0]  cls
);
  always_comb begin
    vld = '0;
    egr = '0;
    cls = '0;
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < C; c++) begin
        if (|grant_all[req_pos(N, c, i, 0) +: N]) begin
          vld[i] = 1'b1;
          egr[i*EW +: EW] = EW'(first_set_idx(32'(grant_all[req_pos(N, c, i, 0) +: N])));
          cls[i*CW +: CW] = CW'(c);
        end
      end
    end
  end
endmodule

// File: rtl/prio_wavefront_arb.sv
module prio_wavefront_arb
  import wfa_pkg::*;
#(
  parameter int N = 4,
  parameter int C = 2,
  localparam int EW = idx_width(N),
  localparam int CW = idx_width(C)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [C*N*N-1:0] req,
  output logic [N-1:0]     match_vld,
  output logic [N*EW-1:0]  match_egr,
  output logic [N*CW-1:0]  match_cls,
  output logic             done
);
  // Token chain between class arrays; index 0 feeds the top class.
  logic [N-1:0]     hunt_chain  [C+1];
  logic [N-1:0]     avail_chain [C+1];
  logic [C*N*N-1:0] grant_all;
  logic [N-1:0]     hunt_left;
  logic [N-1:0]     avail_left;

  assign hunt_chain[0]  = '1;
  assign avail_chain[0] = '1;

  for (genvar c = 0; c < C; c++) begin : g_cls
    wfa_array #(.N(N)) u_arr (
      .hunt_in   (hunt_chain[c]),
      .avail_in  (avail_chain[c]),
      .want      (req[c*N*N +: N*N]),
      .win       (grant_all[c*N*N +: N*N]),
      .hunt_out  (hunt_chain[c+1]),
      .avail_out (avail_chain[c+1])
    );
  end

  assign hunt_left  = hunt_chain[C];
  assign avail_left = avail_chain[C];

  logic [N-1:0]    nxt_vld;
  logic [N*EW-1:0] nxt_egr;
  logic [N*CW-1:0] nxt_cls;

  wfa_encode #(.N(N), .C(C), .EW(EW), .CW(CW)) u_enc (
    .grant_all (grant_all),
    .vld       (nxt_vld),
    .egr       (nxt_egr),
    .cls       (nxt_cls)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_vld <= '0;
      match_egr <= '0;
      match_cls <= '0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        match_vld <= nxt_vld;
        match_egr <= nxt_egr;
        match_cls <= nxt_cls;
      end
    end
  end
endmodule

// File: rtl/prio_wavefront_arb_chk.sv
module prio_wavefront_arb_chk
  import wfa_pkg::*;
#(
  parameter int N  = 4,
  parameter int C  = 2,
  parameter int EW = 2,
  parameter int CW = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [C*N*N-1:0] req,
  input logic [C*N*N-1:0] grant_all,
  input logic [N-1:0]     hunt_left,
  input logic [N-1:0]     avail_left,
  input logic [N-1:0]     match_vld,
  input logic [N*EW-1:0]  match_egr,
  input logic [N*CW-1:0]  match_cls,
  input logic             done
);
  logic [C*N*N-1:0] req_d;
  always_ff @(posedge clk) req_d <= req;

  logic [N-1:0] egr_used;
  logic [N-1:0] backed;
  logic         missed;
  logic [C*N-1:0] ing_grants [N];

  always_comb begin
    egr_used = '0;
    backed   = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vld[i]) begin
        egr_used[int'(match_egr[i*EW +: EW])] = 1'b1;
        backed[i] = req_d[req_pos(N, int'(match_cls[i*CW +: CW]), i, int'(match_egr[i*EW +: EW]))];
      end
    end
  end

  always_comb begin
    missed = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        for (int c = 0; c < C; c++)
          if (hunt_left[i] && avail_left[j] && req[req_pos(N, c, i, j)]) missed = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int c = 0; c < C; c++)
        ing_grants[i][c*N +: N] = grant_all[req_pos(N, c, i, 0) +: N];
  end

  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(match_vld) && $stable(match_egr) && $stable(match_cls)));
  a_r6_egress_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(egr_used) == $countones(match_vld));
  a_r4_grant_backed: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((backed | ~match_vld) == '1));
  a_r5_maximal: assert property (@(posedge clk) disable iff (!rst_n)
    !missed);

  for (genvar i = 0; i < N; i++) begin : g_ing
    a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ing_grants[i]));
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !match_vld[i] |-> (match_egr[i*EW +: EW] == '0 && match_cls[i*CW +: CW] == '0));
  end
endmodule

bind prio_wavefront_arb prio_wavefront_arb_chk #(.N(N), .C(C), .EW(EW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .req        (req),
  .grant_all  (grant_all),
  .hunt_left  (hunt_left),
  .avail_left (avail_left),
  .match_vld  (match_vld),
  .match_egr  (match_egr),
  .match_cls  (match_cls),
  .done       (done)
);

// File: tb/prio_wavefront_arb_bench.sv
module prio_wavefront_arb_bench;
  localparam int N = 4;
  localparam int C = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req = '0;
  logic [3:0]  match_vld;
  logic [7:0]  match_egr;
  logic [3:0]  match_cls;
  logic        done;

  int checks = 0;
  int fails  = 0;

  logic [3:0] last_v;
  logic [7:0] last_e;
  logic [3:0] last_k;

  always #5 clk = ~clk;

  prio_wavefront_arb #(.N(N), .C(C)) u_prio_wavefront_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req       (req),
    .match_vld (match_vld),
    .match_egr (match_egr),
    .match_cls (match_cls),
    .done      (done)
  );

  // Greedy model: classes top first, ingresses ascending, lowest free egress.
  task automatic model(input logic [31:0] r, output logic [3:0] v,
                       output logic [7:0] e, output logic [3:0] k);
    logic [3:0] taken;
    taken = '0; v = '0; e = '0; k = '0;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          if (!v[i] && !taken[j] && r[c*16 + i*4 + j]) begin
            v[i] = 1'b1;
            taken[j] = 1'b1;
            e[i*2 +: 2] = 2'(j);
            k[i] = 1'(c);
          end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic trial(input logic [31:0] r, input string tag);
    logic [3:0] ev;
    logic [7:0] ee;
    logic [3:0] ek;
    logic [3:0] seen;
    logic       dup;
    model(r, ev, ee, ek);
    req = r;
    start = 1'b1;
    @(negedge clk);
    checks++;
    if (match_vld !== ev || match_egr !== ee || match_cls !== ek) begin
      fails++;
      $display("FAIL %s req=%h got vld=%b egr=%h cls=%b expected vld=%b egr=%h cls=%b",
               tag, r, match_vld, match_egr, match_cls, ev, ee, ek);
    end
    // R6 and R2 on the observed outputs
    seen = '0; dup = 1'b0;
    for (int i = 0; i < 4; i++)
      if (match_vld[i]) begin
        if (seen[match_egr[i*2 +: 2]]) dup = 1'b1;
        seen[match_egr[i*2 +: 2]] = 1'b1;
      end
    checks++;
    if (dup || done !== 1'b1) begin
      fails++;
      $display("FAIL R6/R2 req=%h got dup=%b done=%b expected dup=0 done=1", r, dup, done);
    end
    last_v = ev; last_e = ee; last_k = ek;
  endtask

  task automatic idle_step(input logic [31:0] r);
    req = r;
    start = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      fails++;
      $display("FAIL R2 done got %b expected 0", done);
    end
    checks++;
    if (match_vld !== last_v || match_egr !== last_e || match_cls !== last_k) begin
      fails++;
      $display("FAIL R3 got vld=%b egr=%h cls=%b expected vld=%b egr=%h cls=%b",
               match_vld, match_egr, match_cls, last_v, last_e, last_k);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired got running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] s;
    req = 32'hFFFF_FFFF;
    start = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (match_vld !== '0 || match_egr !== '0 || match_cls !== '0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1 got vld=%b egr=%h cls=%b done=%b expected all zero",
               match_vld, match_egr, match_cls, done);
    end
    start = 1'b0;
    rst_n = 1'b1;
    last_v = '0; last_e = '0; last_k = '0;
    idle_step(32'h1234_5678);

    // Directed corner cases (R4, R5, R7)
    trial(32'hFFFF_FFFF, "R4");
    idle_step(32'h0000_FFFF);
    trial(32'hFFFF_000F, "R5");
    trial(32'h0001_8421, "R5");
    trial(32'h000F_0001, "R7");
    idle_step(32'hAAAA_5555);
    trial(32'h0000_0000, "R7");

    // Every class 0 matrix with class 1 empty (R4, R7)
    for (int x = 0; x < 65536; x++) trial({16'h0, 16'(x)}, "R4");
    idle_step(32'hFFFF_FFFF);

    // Every class 1 matrix with class 0 empty (R8)
    for (int x = 0; x < 65536; x++) trial({16'(x), 16'h0}, "R8");
    idle_step(32'h0);

    // Dense pseudo-random pairs with cross-class conflicts (R5, R6)
    s = 32'h1F2E_3D4C;
    for (int x = 0; x < 4000; x++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      trial(s | (s << 7), "R5");
      if (x % 500 == 0) idle_step(~s);
    end

    summary();
    $finish;
  end
endmodule